// File: doc/BRIEF.md
# Warp Issue Exception Checker

This block sits in the issue stage of a SIMT core. It looks at one instruction for one warp, in the same cycle the instruction is presented, and decides whether the warp may execute it. It has two reasons to refuse. The first is a privileged opcode issued outside supervisor mode, which becomes an interrupt request with a fixed cause code. The second is a control-flow opcode whose predicate sends some live threads one way and the rest another way, which becomes a divergent-branch fault. A trap opcode always becomes an interrupt request with its own cause code. The block also holds the warp's interrupt-enable flag, which dedicated enable and disable opcodes change.

The decode stage drives the opcode class flags together with the warp state: the thread mask, the active-thread count, the per-thread predicate bits and the supervisor bit. The block drives back a go signal and the fault outputs in the same cycle. Write-back logic uses `issue_go` to qualify every thread's result. The block has no back-pressure. The instruction is held and judged only in the cycle where `insn_valid` is high, and every decision is purely combinational apart from the interrupt-enable flag.

Top module: `warp_issue_checker`

## Requirements
- R1: A valid instruction with `is_priv`=1 while `super_mode`=0 drives `issue_go`=0, `irq_req`=1 and `irq_cause`=3.
- R2: A thread t is live when t < `active_cnt` and `thread_mask[t]`=1. A live thread is taken when `pred_used`=0 or `pred_bits[t*NUM_PREDS + pred_sel]`=1. A valid control-flow instruction (`is_cflow`=1) with a nonzero taken count that differs from the live count drives `div_fault`=1 and `issue_go`=0.
- R3: A valid control-flow instruction whose taken count is zero, or equals the live count, raises no fault and issues.
- R4: An instruction with `is_cflow`=0 never raises `div_fault`, however its predicate splits the threads.
- R5: Threads at or above `active_cnt` count toward neither the taken count nor the live count, even with their mask and predicate bits set.
- R6: A valid instruction with `is_trap`=1 drives `irq_req`=1, `irq_cause`=0 and `issue_go`=0, in either privilege mode.
- R7: Only one cause is reported. A privilege violation wins over a divergent branch and a trap, and a divergent branch wins over a trap. `irq_req` and `div_fault` are never high together.
- R8: `int_enable` is 0 after reset. An issued instruction (`issue_go`=1) with `is_int_off`=1 clears it, and one with `is_int_on`=1 sets it, from the next rising clock edge onward. If both flags are set, the clear wins.
- R9: An interrupt enable or disable opcode that does not issue, for example because it is privileged and was presented in user mode, leaves `int_enable` unchanged.
- R10: With `insn_valid`=0, `issue_go`, `irq_req` and `div_fault` are 0 and `irq_cause` is 0.
- R11: A valid instruction with no fault drives `issue_go`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| insn_valid | input | 1 | An instruction is presented this cycle |
| is_cflow | input | 1 | Opcode changes control flow |
| is_priv | input | 1 | Opcode needs supervisor mode |
| is_trap | input | 1 | Opcode is a software trap |
| is_int_off | input | 1 | Opcode disables interrupts |
| is_int_on | input | 1 | Opcode enables interrupts |
| pred_used | input | 1 | Instruction is guarded by a predicate |
| pred_sel | input | PIDX_W (2) | Predicate register index |
| pred_bits | input | NUM_THREADS*NUM_PREDS (32) | Predicate bits, thread t predicate p at bit t*NUM_PREDS+p |
| thread_mask | input | NUM_THREADS (8) | Per-thread enable mask |
| active_cnt | input | CNT_W (4) | Number of active threads |
| super_mode | input | 1 | Warp is in supervisor mode |
| issue_go | output | 1 | Instruction may execute and write back |
| irq_req | output | 1 | Interrupt request |
| irq_cause | output | CAUSE_W (4) | Interrupt cause code, 0 when idle |
| div_fault | output | 1 | Divergent-branch fault |
| int_enable | output | 1 | Interrupt-enable flag |

## Verification
`issue_go`, `irq_req`, `irq_cause` and `div_fault` are due in the cycle the instruction is presented, with no register on the way. The bench changes inputs on the falling edge and samples these outputs one nanosecond later, before the next rising edge. `int_enable` passes through a single flop. The bench therefore holds an enable or disable instruction across one rising edge, removes it at the following falling edge, and reads the flag there. This also shows that the flag keeps its value once the instruction has gone.

// File: rtl/wic_pkg.sv
package wic_pkg;

  // Which single outcome the arbiter selected for the issue slot.
  typedef enum logic [1:0] {
    FK_NONE    = 2'd0,
    FK_PRIV    = 2'd1,
    FK_DIVERGE = 2'd2,
    FK_TRAP    = 2'd3
  } fault_kind_e;

  // Width of a thread count able to hold 0..n.
  function automatic int cnt_width(input int n);
    return $clog2(n + 1);
  endfunction

  // Width of an index into n items, never below one bit.
  function automatic int idx_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/wic_thread_count.sv
module wic_thread_count #(
  parameter int NUM_THREADS = 8,
  parameter int NUM_PREDS   = 4,
  localparam int CNT_W  = wic_pkg::cnt_width(NUM_THREADS),
  localparam int PIDX_W = wic_pkg::idx_width(NUM_PREDS)
) (
  input  logic                           pred_used,
  input  logic [PIDX_W-1:0]              pred_sel,
  input  logic [NUM_THREADS*NUM_PREDS-1:0] pred_bits,
  input  logic [NUM_THREADS-1:0]         thread_mask,
  input  logic [CNT_W-1:0]               active_cnt,
  output logic [CNT_W-1:0]               live_cnt,
  output logic [CNT_W-1:0]               taken_cnt
);

  logic [NUM_THREADS-1:0] live_vec;
  logic [NUM_THREADS-1:0] taken_vec;

  // Per-lane qualification: inside the active range, enabled, predicate true.
  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_lane
    logic [NUM_PREDS-1:0] lane_preds;
    logic                 in_range;
    assign lane_preds  = pred_bits[t*NUM_PREDS +: NUM_PREDS];
    assign in_range    = CNT_W'(t) < active_cnt;
    assign live_vec[t] = in_range & thread_mask[t];
    assign taken_vec[t] = live_vec[t] & (~pred_used | lane_preds[pred_sel]);
  end

  always_comb begin
    live_cnt  = '0;
    taken_cnt = '0;
    for (int i = 0; i < NUM_THREADS; i++) begin
      live_cnt  = live_cnt  + CNT_W'(live_vec[i]);
      taken_cnt = taken_cnt + CNT_W'(taken_vec[i]);
    end
  end

endmodule

// File: rtl/wic_fault_arbiter.sv
module wic_fault_arbiter #(
  parameter int NUM_THREADS = 8,
  localparam int CNT_W = wic_pkg::cnt_width(NUM_THREADS)
) (
  input  logic                   insn_valid,
  input  logic                   is_cflow,
  input  logic                   is_priv,
  input  logic                   is_trap,
  input  logic                   super_mode,
  input  logic [CNT_W-1:0]       live_cnt,
  input  logic [CNT_W-1:0]       taken_cnt,
  output wic_pkg::fault_kind_e   kind
);

  logic priv_bad;
  logic split;

  assign priv_bad = is_priv & ~super_mode;
  assign split    = is_cflow & (taken_cnt != '0) & (taken_cnt != live_cnt);

  // Fixed priority: privilege, then divergence, then trap.
  always_comb begin
    kind = wic_pkg::FK_NONE;
    if (insn_valid) begin
      if (priv_bad)     kind = wic_pkg::FK_PRIV;
      else if (split)   kind = wic_pkg::FK_DIVERGE;
      else if (is_trap) kind = wic_pkg::FK_TRAP;
    end
  end

endmodule

// File: rtl/wic_intr_flag.sv
module wic_intr_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic issued,
  input  logic is_int_off,
  input  logic is_int_on,
  output logic int_enable
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      int_enable <= 1'b0;
    end else if (issued) begin
      if (is_int_off)     int_enable <= 1'b0;
      else if (is_int_on) int_enable <= 1'b1;
    end
  end

endmodule

// File: rtl/warp_issue_checker.sv
module warp_issue_checker #(
  parameter int NUM_THREADS = 8,
  parameter int NUM_PREDS   = 4,
  parameter int CAUSE_W     = 4,
  parameter int PRIV_CAUSE  = 3,
  parameter int TRAP_CAUSE  = 0,
  localparam int CNT_W  = wic_pkg::cnt_width(NUM_THREADS),
  localparam int PIDX_W = wic_pkg::idx_width(NUM_PREDS),
  localparam int PB_W   = NUM_THREADS * NUM_PREDS
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   insn_valid,
  input  logic                   is_cflow,
  input  logic                   is_priv,
  input  logic                   is_trap,
  input  logic                   is_int_off,
  input  logic                   is_int_on,
  input  logic                   pred_used,
  input  logic [PIDX_W-1:0]      pred_sel,
  input  logic [PB_W-1:0]        pred_bits,
  input  logic [NUM_THREADS-1:0] thread_mask,
  input  logic [CNT_W-1:0]       active_cnt,
  input  logic                   super_mode,
  output logic                   issue_go,
  output logic                   irq_req,
  output logic [CAUSE_W-1:0]     irq_cause,
  output logic                   div_fault,
  output logic                   int_enable
);

  logic [CNT_W-1:0]     live_cnt;
  logic [CNT_W-1:0]     taken_cnt;
  wic_pkg::fault_kind_e kind;

  wic_thread_count #(
    .NUM_THREADS(NUM_THREADS),
    .NUM_PREDS  (NUM_PREDS)
  ) u_count (
    .pred_used  (pred_used),
    .pred_sel   (pred_sel),
    .pred_bits  (pred_bits),
    .thread_mask(thread_mask),
    .active_cnt (active_cnt),
    .live_cnt   (live_cnt),
    .taken_cnt  (taken_cnt)
  );

  wic_fault_arbiter #(
    .NUM_THREADS(NUM_THREADS)
  ) u_arb (
    .insn_valid(insn_valid),
    .is_cflow  (is_cflow),
    .is_priv   (is_priv),
    .is_trap   (is_trap),
    .super_mode(super_mode),
    .live_cnt  (live_cnt),
    .taken_cnt (taken_cnt),
    .kind      (kind)
  );

  always_comb begin
    issue_go  = 1'b0;
    irq_req   = 1'b0;
    irq_cause = '0;
    div_fault = 1'b0;
    unique case (kind)
      wic_pkg::FK_NONE:    issue_go = insn_valid;
      wic_pkg::FK_PRIV:    begin irq_req = 1'b1; irq_cause = CAUSE_W'(PRIV_CAUSE); end
      wic_pkg::FK_DIVERGE: div_fault = 1'b1;
      wic_pkg::FK_TRAP:    begin irq_req = 1'b1; irq_cause = CAUSE_W'(TRAP_CAUSE); end
      default:             issue_go = 1'b0;
    endcase
  end

  wic_intr_flag u_flag (
    .clk       (clk),
    .rst_n     (rst_n),
    .issued    (issue_go),
    .is_int_off(is_int_off),
    .is_int_on (is_int_on),
    .int_enable(int_enable)
  );

endmodule

// File: rtl/wic_checker.sv
module wic_checker #(
  parameter int CAUSE_W    = 4,
  parameter int PRIV_CAUSE = 3,
  parameter int TRAP_CAUSE = 0
) (
  input logic               clk,
  input logic               rst_n,
  input logic               insn_valid,
  input logic               is_priv,
  input logic               is_trap,
  input logic               is_cflow,
  input logic               is_int_off,
  input logic               is_int_on,
  input logic               super_mode,
  input logic               issue_go,
  input logic               irq_req,
  input logic [CAUSE_W-1:0] irq_cause,
  input logic               div_fault,
  input logic               int_enable
);

  p_priv_trap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    insn_valid && is_priv && !super_mode |->
      !issue_go && irq_req && irq_cause == CAUSE_W'(PRIV_CAUSE));

  p_flat_no_split_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !is_cflow |-> !div_fault);

  p_trap_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    insn_valid && is_trap && (super_mode || !is_priv) && !div_fault |->
      irq_req && irq_cause == CAUSE_W'(TRAP_CAUSE) && !issue_go);

  p_one_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({issue_go, irq_req, div_fault}));

  p_flag_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    issue_go && is_int_off |=> !int_enable);

  p_flag_on_r8: assert property (@(posedge clk) disable iff (!rst_n)
    issue_go && is_int_on && !is_int_off |=> int_enable);

  p_flag_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(issue_go && (is_int_on || is_int_off)) |=> $stable(int_enable));

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !insn_valid |-> !issue_go && !irq_req && !div_fault && irq_cause == '0);

endmodule

bind warp_issue_checker wic_checker #(
  .CAUSE_W   (CAUSE_W),
  .PRIV_CAUSE(PRIV_CAUSE),
  .TRAP_CAUSE(TRAP_CAUSE)
) u_wic_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .insn_valid(insn_valid),
  .is_priv   (is_priv),
  .is_trap   (is_trap),
  .is_cflow  (is_cflow),
  .is_int_off(is_int_off),
  .is_int_on (is_int_on),
  .super_mode(super_mode),
  .issue_go  (issue_go),
  .irq_req   (irq_req),
  .irq_cause (irq_cause),
  .div_fault (div_fault),
  .int_enable(int_enable)
);

// File: tb/tb_warp_issue_checker.sv
`timescale 1ns/1ps
module tb_warp_issue_checker;

  localparam int NT = 8;
  localparam int NP = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        insn_valid, is_cflow, is_priv, is_trap, is_int_off, is_int_on;
  logic        pred_used, super_mode;
  logic [1:0]  pred_sel;
  logic [31:0] pred_bits;
  logic [7:0]  thread_mask;
  logic [3:0]  active_cnt;
  logic        issue_go, irq_req, div_fault, int_enable;
  logic [3:0]  irq_cause;

  int n_checks = 0;
  int n_fail   = 0;

  always #2 clk = ~clk;

  warp_issue_checker dut (
    .clk(clk), .rst_n(rst_n), .insn_valid(insn_valid), .is_cflow(is_cflow),
    .is_priv(is_priv), .is_trap(is_trap), .is_int_off(is_int_off),
    .is_int_on(is_int_on), .pred_used(pred_used), .pred_sel(pred_sel),
    .pred_bits(pred_bits), .thread_mask(thread_mask), .active_cnt(active_cnt),
    .super_mode(super_mode), .issue_go(issue_go), .irq_req(irq_req),
    .irq_cause(irq_cause), .div_fault(div_fault), .int_enable(int_enable)
  );

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Packed view of the combinational outputs: {go, irq, cause, div}.
  function automatic int outs();
    return {issue_go, irq_req, irq_cause, div_fault};
  endfunction

  function automatic int pack(input bit go, input bit irq, input int cause, input bit dv);
    return {go, irq, 4'(cause), dv};
  endfunction

  // Place an 8-bit per-thread vector into predicate p of every thread.
  function automatic logic [31:0] spread(input logic [7:0] v, input int p);
    logic [31:0] r = '0;
    for (int t = 0; t < NT; t++) r[t*NP + p] = v[t];
    return r;
  endfunction

  task automatic idle();
    insn_valid = 0; is_cflow = 0; is_priv = 0; is_trap = 0;
    is_int_off = 0; is_int_on = 0; pred_used = 0; pred_sel = 0;
    pred_bits = '0; thread_mask = 8'hFF; active_cnt = 4'd8; super_mode = 0;
  endtask

  // Branch with predicate p over the given mask/active/predicate bits.
  task automatic branch(input logic [7:0] m, input int act, input logic [7:0] pv,
                        input bit cf);
    @(negedge clk);
    idle();
    insn_valid = 1; is_cflow = cf; pred_used = 1; pred_sel = 2'd2;
    pred_bits = spread(pv, 2) | spread(~pv, 1);
    thread_mask = m; active_cnt = 4'(act);
    #1;
  endtask

  task automatic t_reset();
    @(negedge clk); idle(); #1;
    check("R10 idle outputs", outs(), pack(0, 0, 0, 0));
    check("R8 flag after reset", int_enable, 0);
  endtask

  task automatic t_plain();
    @(negedge clk); idle(); insn_valid = 1; #1;
    check("R11 plain op issues", outs(), pack(1, 0, 0, 0));
  endtask

  task automatic t_priv();
    @(negedge clk); idle(); insn_valid = 1; is_priv = 1; #1;
    check("R1 privileged in user mode", outs(), pack(0, 1, 3, 0));
    super_mode = 1; #1;
    check("R1 privileged in supervisor", outs(), pack(1, 0, 0, 0));
  endtask

  task automatic t_diverge();
    branch(8'hFF, 8, 8'h0F, 1);
    check("R2 half taken", outs(), pack(0, 0, 0, 1));
    branch(8'h0F, 8, 8'h3C, 1);
    check("R2 masked split", outs(), pack(0, 0, 0, 1));
  endtask

  task automatic t_uniform();
    branch(8'hFF, 8, 8'h00, 1);
    check("R3 none taken", outs(), pack(1, 0, 0, 0));
    branch(8'hFF, 8, 8'hFF, 1);
    check("R3 all taken", outs(), pack(1, 0, 0, 0));
    branch(8'h0F, 8, 8'h0F, 1);
    check("R3 all live taken", outs(), pack(1, 0, 0, 0));
    branch(8'hA5, 8, 8'h00, 1);
    pred_used = 0; #1;
    check("R3 unpredicated", outs(), pack(1, 0, 0, 0));
  endtask

  task automatic t_flat();
    branch(8'hFF, 8, 8'h0F, 0);
    check("R4 non-branch split", outs(), pack(1, 0, 0, 0));
  endtask

  task automatic t_active();
    branch(8'hFF, 4, 8'hCF, 1);
    check("R5 upper threads ignored", outs(), pack(1, 0, 0, 0));
    branch(8'hFF, 4, 8'hF7, 1);
    check("R5 split inside range", outs(), pack(0, 0, 0, 1));
  endtask

  task automatic t_trap();
    @(negedge clk); idle(); insn_valid = 1; is_trap = 1; #1;
    check("R6 trap user", outs(), pack(0, 1, 0, 0));
    super_mode = 1; #1;
    check("R6 trap supervisor", outs(), pack(0, 1, 0, 0));
  endtask

  task automatic t_priority();
    branch(8'hFF, 8, 8'h0F, 1);
    is_priv = 1; #1;
    check("R7 priv over divergence", outs(), pack(0, 1, 3, 0));
    is_priv = 0; is_trap = 1; #1;
    check("R7 divergence over trap", outs(), pack(0, 0, 0, 1));
  endtask

  task automatic flag_op(input bit sup, input bit off, input bit on);
    @(negedge clk); idle();
    insn_valid = 1; is_priv = 1; super_mode = sup; is_int_off = off; is_int_on = on;
    @(negedge clk); idle(); #1;
  endtask

  task automatic t_flag();
    flag_op(1, 0, 1);
    check("R8 enable sets flag", int_enable, 1);
    flag_op(0, 1, 0);
    check("R9 user disable ignored", int_enable, 1);
    flag_op(1, 1, 1);
    check("R8 disable wins", int_enable, 0);
    flag_op(0, 0, 1);
    check("R9 user enable ignored", int_enable, 0);
    flag_op(1, 0, 1);
    flag_op(1, 1, 0);
    check("R8 disable clears flag", int_enable, 0);
  endtask

  initial begin
    fork
      begin
        #(4 * 100000);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
      end
    join_none
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_plain();
    t_priv();
    t_diverge();
    t_uniform();
    t_flat();
    t_active();
    t_trap();
    t_priority();
    t_flag();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule